// File: doc/BRIEF.md
# Signed Integer Remainder Unit

This block produces the signed remainder of two XLEN-bit integer operands. The quotient is truncated toward zero, so any nonzero remainder carries the sign of the dividend. Two corner cases have fixed results and never trap. A zero divisor returns the dividend unchanged. The most negative value divided by minus one returns zero. Both corner cases finish one cycle after the operation is accepted. Every other operand pair goes through a restoring shift-subtract loop. The loop works on operand magnitudes, takes one bit per cycle, and fixes the sign of the result at the end.

The unit sits beside an execution pipeline and is driven by a single-cycle `start` pulse. On that pulse it takes the two operand values, the 32-bit instruction word and an enable flag that says whether integer multiply/divide is switched on. While it works, `busy` stays high. It finishes with a one-cycle `done` pulse, and the result and destination index are valid in that same cycle. The source register indices are decoded from the instruction word combinationally, so that a register file can supply the operands. When the enable flag is clear, the operation ends in an illegal-instruction flag and nothing is written.

Top module: `srem_unit`

## Requirements
- R1: `src1_idx` equals instruction bits 19:15 and `src2_idx` equals bits 24:20 at all times. `dst_idx` presented with `done` equals bits 11:7 of the instruction word captured with the accepted `start`.
- R2: A zero divisor gives `result` equal to the dividend, with `illegal` low and `wr_en` high. `done` rises on the first clock edge after the edge that accepted `start`.
- R3: A dividend with only its top bit set, combined with an all-ones divisor, gives `result` zero. The latency is the same as in R2.
- R4: In all other enabled cases `result` equals the dividend minus the truncated quotient times the divisor. A nonzero result has the dividend's sign. `done` rises XLEN+1 edges after the accepting edge.
- R5: If `ext_en` is low when `start` is accepted, `done` and `illegal` pulse together on the first edge after the accepting edge, and `wr_en` stays low. This check takes priority over R2 and R3.
- R6: `busy` is high from the edge after acceptance until `done` rises. `done` is a single-cycle pulse that never coincides with `busy`. `wr_en` is high exactly when `done` is high and `illegal` is low.
- R7: A `start` that arrives while `busy` is high is ignored. It changes neither the in-flight result nor its timing, and it produces no extra `done`.
- R8: Holding `rst_n` low at a clock edge clears `busy`, `done`, `illegal` and `wr_en`, and abandons any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; accepted only while not busy |
| insn | input | 32 | Instruction word, captured with start |
| ext_en | input | 1 | Multiply/divide enable, captured with start |
| dividend | input | XLEN | Signed dividend, captured with start |
| divisor | input | XLEN | Signed divisor, captured with start |
| src1_idx | output | 5 | First source index decoded from insn |
| src2_idx | output | 5 | Second source index decoded from insn |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-instruction flag, valid with done |
| wr_en | output | 1 | Result write request, valid with done |
| dst_idx | output | 5 | Destination index, valid with done |
| result | output | XLEN | Signed remainder, valid with done |

## Verification
The bench builds the unit with XLEN = 32. At that width a normal operation takes 34 cycles, and the most negative value is a 32-bit quantity that a directed list of operands can reach exactly. This makes the overflow pair, the minimum value divided by itself and by positive divisors, and all four sign combinations part of the stimulus. A pseudo-random sweep then mixes full-width operands with small divisors, so that long runs of both restoring outcomes are exercised.

// File: rtl/srem_pkg.sv
// Package srem_pkg
// Shared constants and the controller state type for the remainder unit.
// Assumes a 32-bit instruction word with 5-bit register index fields.
package srem_pkg;
    localparam int INSN_W  = 32;
    localparam int RIDX_W  = 5;
    localparam int DST_LSB = 7;
    localparam int SA_LSB  = 15;
    localparam int SB_LSB  = 20;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_CHECK = 2'd1,
        SR_RUN   = 2'd2
    } sr_state_e;
endpackage

// File: rtl/srem_decode.sv
// Module srem_decode
// Pulls the three register index fields out of an instruction word.
// Purely combinational; assumes the field positions given in srem_pkg.
module srem_decode
    import srem_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic [RIDX_W-1:0] dst,
    output logic [RIDX_W-1:0] sa,
    output logic [RIDX_W-1:0] sb
);
    // Field extraction
    always_comb begin
        dst = insn[DST_LSB +: RIDX_W];
        sa  = insn[SA_LSB  +: RIDX_W];
        sb  = insn[SB_LSB  +: RIDX_W];
    end
endmodule

// File: rtl/srem_prep.sv
// Module srem_prep
// Classifies an operand pair (zero divisor, signed overflow) and forms the
// unsigned magnitudes used by the iterative loop. Combinational. Assumes
// two's complement operands; the magnitude of the most negative value is
// representable as an unsigned XLEN-bit number.
module srem_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] dvd_mag,
    output logic [XLEN-1:0] dvs_mag,
    output logic            dvd_neg,
    output logic            zero_div,
    output logic            ovf
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    // Sign split and corner-case detection
    always_comb begin
        dvd_neg  = dvd[XLEN-1];
        dvd_mag  = dvd[XLEN-1] ? (~dvd + XLEN'(1)) : dvd;
        dvs_mag  = dvs[XLEN-1] ? (~dvs + XLEN'(1)) : dvs;
        zero_div = (dvs == '0);
        ovf      = (dvd == MOST_NEG) && (dvs == '1);
    end
endmodule

// File: rtl/srem_step.sv
// Module srem_step
// One restoring shift-subtract step: shifts the next dividend bit into the
// partial remainder and subtracts the divisor magnitude when it fits.
// Assumes the incoming partial remainder is below the divisor magnitude.
module srem_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] part,
    input  logic            nbit,
    input  logic [XLEN-1:0] dvs_mag,
    output logic [XLEN-1:0] part_nxt
);
    logic [XLEN:0] widened;
    logic [XLEN:0] trial;

    // Trial subtraction and restore choice
    always_comb begin
        widened  = {part, nbit};
        trial    = widened - {1'b0, dvs_mag};
        part_nxt = trial[XLEN] ? widened[XLEN-1:0] : trial[XLEN-1:0];
    end
endmodule

// File: rtl/srem_unit.sv
// Module srem_unit
// Multi-cycle signed remainder unit with start/busy/done handshake.
// Accepts start only when idle; classifies the operands one cycle later;
// corner cases and disabled-extension requests finish at once, others run
// XLEN restoring steps and apply the dividend's sign on the final step.
// Assumes operands stay in the captured registers until the next start.
module srem_unit
    import srem_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [INSN_W-1:0]   insn,
    input  logic                ext_en,
    input  logic [XLEN-1:0]     dividend,
    input  logic [XLEN-1:0]     divisor,
    output logic [RIDX_W-1:0]   src1_idx,
    output logic [RIDX_W-1:0]   src2_idx,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic                wr_en,
    output logic [RIDX_W-1:0]   dst_idx,
    output logic [XLEN-1:0]     result
);
    localparam int CNT_W = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(XLEN - 1);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    sr_state_e         state_q;
    logic [XLEN-1:0]   dvd_q, dvs_q;
    logic              en_q;
    logic [RIDX_W-1:0] dst_q, dst_dec;
    logic [XLEN-1:0]   shreg_q, part_q, dvsm_q;
    logic              neg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q, ill_q, wr_q;
    logic [XLEN-1:0]   res_q;

    logic [XLEN-1:0]   dvd_mag, dvs_mag, part_nxt;
    logic              dvd_neg, zero_div, ovf;

    srem_decode u_dec (
        .insn (insn),
        .dst  (dst_dec),
        .sa   (src1_idx),
        .sb   (src2_idx)
    );

    srem_prep #(.XLEN(XLEN)) u_prep (
        .dvd      (dvd_q),
        .dvs      (dvs_q),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .dvd_neg  (dvd_neg),
        .zero_div (zero_div),
        .ovf      (ovf)
    );

    srem_step #(.XLEN(XLEN)) u_step (
        .part     (part_q),
        .nbit     (shreg_q[XLEN-1]),
        .dvs_mag  (dvsm_q),
        .part_nxt (part_nxt)
    );

    // Controller and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            wr_q    <= 1'b0;
            dvd_q   <= '0;
            dvs_q   <= '0;
            en_q    <= 1'b0;
            dst_q   <= '0;
            shreg_q <= '0;
            part_q  <= '0;
            dvsm_q  <= '0;
            neg_q   <= 1'b0;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            wr_q   <= 1'b0;
            unique case (state_q)
                SR_IDLE: begin
                    if (start) begin
                        dvd_q   <= dividend;
                        dvs_q   <= divisor;
                        en_q    <= ext_en;
                        dst_q   <= dst_dec;
                        state_q <= SR_CHECK;
                    end
                end
                SR_CHECK: begin
                    if (!en_q) begin
                        done_q  <= 1'b1;
                        ill_q   <= 1'b1;
                        state_q <= SR_IDLE;
                    end else if (zero_div) begin
                        done_q  <= 1'b1;
                        wr_q    <= 1'b1;
                        res_q   <= dvd_q;
                        state_q <= SR_IDLE;
                    end else if (ovf) begin
                        done_q  <= 1'b1;
                        wr_q    <= 1'b1;
                        res_q   <= '0;
                        state_q <= SR_IDLE;
                    end else begin
                        shreg_q <= dvd_mag;
                        part_q  <= '0;
                        dvsm_q  <= dvs_mag;
                        neg_q   <= dvd_neg;
                        cnt_q   <= '0;
                        state_q <= SR_RUN;
                    end
                end
                SR_RUN: begin
                    part_q  <= part_nxt;
                    shreg_q <= {shreg_q[XLEN-2:0], 1'b0};
                    cnt_q   <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_STEP) begin
                        done_q  <= 1'b1;
                        wr_q    <= 1'b1;
                        res_q   <= neg_q ? (~part_nxt + XLEN'(1)) : part_nxt;
                        state_q <= SR_IDLE;
                    end
                end
                default: state_q <= SR_IDLE;
            endcase
        end
    end

    // Output mapping
    always_comb begin
        busy    = (state_q != SR_IDLE);
        done    = done_q;
        illegal = ill_q;
        wr_en   = wr_q;
        dst_idx = dst_q;
        result  = res_q;
    end

    // R6: completion is one cycle wide and never overlaps busy
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R5: illegal completes without a write
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wr_en));
    // R2: zero divisor passes the captured dividend through
    a_r2_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && dvs_q == '0) |-> (result == dvd_q));
    // R3: signed overflow pair yields zero
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && dvd_q == MOST_NEG && dvs_q == '1) |-> (result == '0));
    // R4: nonzero remainder follows dividend sign
    a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_en && dvs_q != '0 && result != '0) |-> (result[XLEN-1] == dvd_q[XLEN-1]));
    // R7: a start while busy leaves captured operands untouched
    a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dvd_q) && $stable(dvs_q)));
endmodule

// File: tb/srem_unit_test.sv
module srem_unit_test;
    localparam int XLEN = 32;
    localparam int CLK_PERIOD = 10;
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     insn = '0;
    logic            ext_en = 1'b1;
    logic [XLEN-1:0] dividend = '0;
    logic [XLEN-1:0] divisor = '0;
    logic [4:0]      src1_idx, src2_idx, dst_idx;
    logic            busy, done, illegal, wr_en;
    logic [XLEN-1:0] result;

    typedef struct {
        logic            ill;
        logic [XLEN-1:0] res;
        logic [4:0]      rd;
        int              issue;
        int              lat;
        string           tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pushed = 0;
    int seen = 0;

    srem_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .ext_en(ext_en),
        .dividend(dividend), .divisor(divisor), .src1_idx(src1_idx),
        .src2_idx(src2_idx), .busy(busy), .done(done), .illegal(illegal),
        .wr_en(wr_en), .dst_idx(dst_idx), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Drive one request; push its expectation when push is set
    task automatic issue(input logic [31:0] ins, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic en,
                         input string tag, input bit push);
        exp_t e;
        logic signed [XLEN-1:0] sa, sb, sr;
        while (sbq.size() != 0) @(negedge clk);
        sa = a;
        sb = b;
        e.ill = !en;
        e.rd = ins[11:7];
        e.tag = tag;
        e.res = '0;
        e.lat = 2;
        if (!en) e.res = '0;
        else if (b == '0) e.res = a;
        else if (a == MOST_NEG && b == '1) e.res = '0;
        else begin
            sr = sa % sb;
            e.res = sr;
            e.lat = XLEN + 2;
        end
        insn = ins;
        dividend = a;
        divisor = b;
        ext_en = en;
        start = 1'b1;
        e.issue = cyc;
        if (push) begin
            sbq.push_back(e);
            pushed++;
        end
        #1;
        check(src1_idx == ins[19:15], "R1", "src1_idx", 64'(src1_idx), 64'(ins[19:15]));
        check(src2_idx == ins[24:20], "R1", "src2_idx", 64'(src2_idx), 64'(ins[24:20]));
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after accept", 64'(busy), 64'd1);
    endtask

    // Monitor: pop and compare on each completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            seen++;
            if (sbq.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
            end else begin
                e = sbq.pop_front();
                check(illegal == e.ill, "R5", {e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
                check(wr_en == !e.ill, "R6", {e.tag, " wr_en"}, 64'(wr_en), 64'(!e.ill));
                check(busy == 1'b0, "R6", {e.tag, " busy with done"}, 64'(busy), 64'd0);
                check(dst_idx == e.rd, "R1", {e.tag, " dst_idx"}, 64'(dst_idx), 64'(e.rd));
                check(cyc - e.issue == e.lat, e.tag, "latency",
                      64'(cyc - e.issue), 64'(e.lat));
                if (!e.ill)
                    check(result == e.res, e.tag, "result", 64'(result), 64'(e.res));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [XLEN-1:0] ra, rb;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!busy && !done && !illegal && !wr_en, "R8", "reset outputs",
              {60'd0, busy, done, illegal, wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: sign combinations and magnitudes
        issue(32'h00A5_0F13, XLEN'(17), XLEN'(5), 1'b1, "R4", 1'b1);
        issue(32'h0128_4233, -XLEN'(17), XLEN'(5), 1'b1, "R4", 1'b1);
        issue(32'h01F0_0AB3, XLEN'(17), -XLEN'(5), 1'b1, "R4", 1'b1);
        issue(32'h0000_0F93, -XLEN'(17), -XLEN'(5), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, XLEN'(4), XLEN'(7), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, -XLEN'(4), XLEN'(7), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, XLEN'(0), XLEN'(5), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, ~MOST_NEG, XLEN'(3), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, MOST_NEG, XLEN'(3), 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, MOST_NEG, MOST_NEG, 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, ~MOST_NEG, MOST_NEG, 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, '1, MOST_NEG, 1'b1, "R4", 1'b1);
        issue(32'h0033_8393, -XLEN'(5), '1, 1'b1, "R4", 1'b1);
        // R2: zero divisor
        issue(32'h0020_8F33, XLEN'(123), '0, 1'b1, "R2", 1'b1);
        issue(32'h0020_8133, MOST_NEG, '0, 1'b1, "R2", 1'b1);
        issue(32'h0020_8133, -XLEN'(5), '0, 1'b1, "R2", 1'b1);
        // R3: overflow pair
        issue(32'h0031_05B3, MOST_NEG, '1, 1'b1, "R3", 1'b1);
        // R5: extension disabled, including corner operands
        issue(32'h0041_8233, XLEN'(9), XLEN'(2), 1'b0, "R5", 1'b1);
        issue(32'h0041_8233, XLEN'(9), '0, 1'b0, "R5", 1'b1);
        issue(32'h0041_8233, MOST_NEG, '1, 1'b0, "R5", 1'b1);

        // R7: starts while busy are ignored
        issue(32'h0052_8333, XLEN'(100), XLEN'(7), 1'b1, "R7", 1'b1);
        for (int k = 0; k < 3; k++) begin
            insn = 32'hFFFF_FFFF;
            dividend = XLEN'(55);
            divisor = '0;
            ext_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (XLEN + 6) @(negedge clk);
        check(seen == pushed, "R7", "done count", 64'(seen), 64'(pushed));

        // R8: reset abandons an operation in flight
        issue(32'h0062_8333, XLEN'(1000), XLEN'(7), 1'b1, "R8", 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !illegal && !wr_en, "R8", "reset mid-operation",
              {60'd0, busy, done, illegal, wr_en}, 64'd0);
        rst_n = 1'b1;
        repeat (XLEN + 6) @(negedge clk);
        check(seen == pushed, "R8", "no done after reset", 64'(seen), 64'(pushed));

        // R4: pseudo-random sweep
        for (int i = 0; i < 40; i++) begin
            ra = XLEN'($urandom);
            rb = XLEN'($urandom);
            if (i % 3 == 0) rb = XLEN'(int'($urandom % 9) - 4);
            issue($urandom, ra, rb, 1'b1, (rb == '0) ? "R2" : "R4", 1'b1);
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(seen == pushed, "R6", "all requests completed", 64'(seen), 64'(pushed));
        summary();
        $finish;
    end
endmodule